// File: doc/BRIEF.md
# Chopped Dual-Converter Stream Reconstructor

This block drives the select line of a pair of analog input switches with a square wave, so that two sampling converters alternate between a device-under-test signal and a stimulus signal. While the phase line is low, converter A sees the device signal and converter B sees the stimulus. While it is high, the two are swapped. The block then crosses the two converter streams back over and produces one unbroken device stream and one unbroken stimulus stream. Each output draws from both converters for equal shares of every chopping period, so the slow gain drift of either converter affects both streams in the same way. A later ratio of the two demodulated amplitudes then cancels that drift.

The chopping half-period is set in clock cycles. With the default of 40000 cycles at an 80 MHz sample clock, the chopping rate is 1 kHz. The routing select is the phase line delayed by a programmable number of cycles, which matches the latency of the converters. A programmable number of samples after each routing change is flagged invalid to hide switch settling. During those samples the last valid pair stays on the outputs. Both outputs share one valid flag, so the two streams stay aligned.

Top module: `chop_recon`

## Requirements
- R1: While reset is high and after it is released, the phase line is 0, the valid flag is 0, and both output words are 0. They stay at these values until the first strobed sample is accepted.
- R2: The phase line inverts once every `half_period` clock cycles. The first inversion comes `half_period` rising edges after reset is released. A `half_period` of 0 behaves as 1.
- R3: When a strobed sample is accepted with routing select 0, the device output takes `adc_a_data` and the stimulus output takes `adc_b_data`. With routing select 1 the roles are swapped. The result appears, with valid high, one clock after the strobed edge.
- R4: The routing select is the phase line delayed by `latency` clock cycles (0 to 15). With 0 the select follows the phase line itself.
- R5: When the routing select differs from its value at the previous edge, the next `blank_len` strobed samples (0 to 15, counting the one at that edge) are flagged invalid. Every strobed sample after those is valid.
- R6: While the valid flag is low, both output words keep the last values that were flagged valid.
- R7: A clock edge without the strobe leaves the valid flag low in the following cycle and does not change the output words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one converter sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | 20 | Chopping half-period in clock cycles |
| latency | input | 4 | Delay of the routing select behind the phase line |
| blank_len | input | 4 | Samples flagged invalid after each routing change |
| adc_strobe | input | 1 | Both converter words are valid this cycle |
| adc_a_data | input | 14 | Converter A sample, two's complement |
| adc_b_data | input | 14 | Converter B sample, two's complement |
| sw_phase | output | 1 | Switch select line driven to the analog front end |
| dut_data | output | 14 | Reconstructed device-under-test stream |
| stim_data | output | 14 | Reconstructed stimulus stream |
| out_valid | output | 1 | Shared valid flag of both output words |

## Verification
The phase line and the output registers change at the same rising edge that consumes their inputs. An output pair is due one edge after its strobed sample. Its routing depends on the phase value `latency` edges before that edge. The bench drives inputs at the falling edge and predicts the next edge from a phase history it records from `sw_phase` itself. It then compares the ports at the following falling edge, so each check reads exactly the cycle in which the result settles. Blanking and hold are predicted from the routing changes that this history implies.

// File: rtl/chop_pkg.sv
package chop_pkg;

    localparam int SAMPLE_W = 14;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t dut;
        sample_t stim;
    } chan_pair_t;

    // Crossover: select 0 sends converter A to the device stream.
    function automatic chan_pair_t route_pair(input logic sel,
                                              input sample_t a,
                                              input sample_t b);
        chan_pair_t p;
        p.dut  = sel ? b : a;
        p.stim = sel ? a : b;
        return p;
    endfunction

endpackage

// File: rtl/chop_phase_gen.sv
module chop_phase_gen #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] half_period,
    output logic             phase_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = (half_period == '0) ? '0 : half_period - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            phase_o <= 1'b0;
        end else if (cnt >= limit) begin
            cnt     <= '0;
            phase_o <= ~phase_o;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    // R2: the phase only moves on the cycle the count restarts
    a_r2_toggle_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase_o != $past(phase_o)) |-> (cnt == '0));

endmodule

// File: rtl/chop_sel_delay.sv
module chop_sel_delay #(
    parameter int LAT_MAX = 15,
    localparam int LAT_W  = $clog2(LAT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_i,
    input  logic [LAT_W-1:0] latency,
    output logic             sel_o
);
    logic [LAT_MAX:0] taps;

    assign taps[0] = phase_i;

    for (genvar i = 1; i <= LAT_MAX; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) taps[i] <= 1'b0;
            else     taps[i] <= taps[i-1];
        end
    end

    assign sel_o = (int'(latency) > LAT_MAX) ? taps[LAT_MAX] : taps[latency];

    // R4: a one-cycle setting tracks the phase seen one edge earlier
    a_r4_one_tap: assert property (@(posedge clk) disable iff (rst)
        ($stable(latency) && latency == LAT_W'(1)) |-> (sel_o == $past(phase_i)));

endmodule

// File: rtl/chop_router.sv
module chop_router
    import chop_pkg::*;
#(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic             strobe,
    input  sample_t          adc_a,
    input  sample_t          adc_b,
    input  logic [BLK_W-1:0] blank_len,
    output chan_pair_t       pair_o,
    output logic             valid_o
);
    logic             sel_prev;
    logic [BLK_W-1:0] rem;
    logic [BLK_W-1:0] rem_eff;
    logic             sel_edge;

    assign sel_edge = (sel_i != sel_prev);
    assign rem_eff  = sel_edge ? blank_len : rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev <= 1'b0;
            rem      <= '0;
            valid_o  <= 1'b0;
            pair_o   <= '0;
        end else begin
            sel_prev <= sel_i;
            if (strobe) begin
                if (rem_eff != '0) begin
                    valid_o <= 1'b0;
                    rem     <= rem_eff - 1'b1;
                end else begin
                    valid_o <= 1'b1;
                    pair_o  <= route_pair(sel_i, adc_a, adc_b);
                    rem     <= '0;
                end
            end else begin
                valid_o <= 1'b0;
                rem     <= rem_eff;
            end
        end
    end

    // R3: select 0 puts converter A on the device stream
    a_r3_route_low: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !$past(sel_i)) |-> (pair_o.dut == $past(adc_a)));
    // R3: select 1 puts converter A on the stimulus stream
    a_r3_route_high: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(sel_i)) |-> (pair_o.stim == $past(adc_a)));
    // R5: a strobed sample at a routing change is blanked when blanking is on
    a_r5_blank_edge: assert property (@(posedge clk) disable iff (rst)
        (strobe && sel_edge && blank_len != '0) |=> !valid_o);
    // R6: invalid cycles keep the previous words
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(pair_o));
    // R7: no strobe, no valid
    a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> !valid_o);

endmodule

// File: rtl/chop_recon.sv
module chop_recon
    import chop_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int LAT_MAX = 15,
    parameter int BLK_W   = 4,
    localparam int LAT_W  = $clog2(LAT_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    half_period,
    input  logic [LAT_W-1:0]    latency,
    input  logic [BLK_W-1:0]    blank_len,
    input  logic                adc_strobe,
    input  logic [SAMPLE_W-1:0] adc_a_data,
    input  logic [SAMPLE_W-1:0] adc_b_data,
    output logic                sw_phase,
    output logic [SAMPLE_W-1:0] dut_data,
    output logic [SAMPLE_W-1:0] stim_data,
    output logic                out_valid
);
    logic       route_sel;
    chan_pair_t pair;

    chop_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .half_period (half_period),
        .phase_o     (sw_phase)
    );

    chop_sel_delay #(.LAT_MAX(LAT_MAX)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .phase_i (sw_phase),
        .latency (latency),
        .sel_o   (route_sel)
    );

    chop_router #(.BLK_W(BLK_W)) u_router (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (route_sel),
        .strobe    (adc_strobe),
        .adc_a     (sample_t'(adc_a_data)),
        .adc_b     (sample_t'(adc_b_data)),
        .blank_len (blank_len),
        .pair_o    (pair),
        .valid_o   (out_valid)
    );

    assign dut_data  = pair.dut;
    assign stim_data = pair.stim;

    // R1: the cycle after a reset edge shows the cleared state
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!sw_phase && !out_valid && dut_data == '0 && stim_data == '0));

endmodule

// File: tb/chop_recon_test.sv
module chop_recon_test;
    import chop_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] half_period = 20'd4;
    logic [3:0]  latency = '0;
    logic [3:0]  blank_len = '0;
    logic        adc_strobe = 1'b0;
    logic [13:0] adc_a_data = '0;
    logic [13:0] adc_b_data = '0;
    logic        sw_phase;
    logic [13:0] dut_data, stim_data;
    logic        out_valid;

    always #5 clk = ~clk;

    chop_recon uut (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // bench model state
    logic        m_ph;
    int          m_cnt;
    logic [15:0] hist;
    logic        m_prev;
    int          m_rem;
    logic        e_valid;
    logic [13:0] e_dut, e_stim;
    string       tag_v, tag_d;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog R1: cycles %0d expected below %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic start_cfg(int h, int l, int b);
        half_period = 20'(h);
        latency     = 4'(l);
        blank_len   = 4'(b);
        adc_strobe  = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 phase", 32'(sw_phase), 0);
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 dut", 32'(dut_data), 0);
        chk("R1 stim", 32'(stim_data), 0);
        m_ph = 0; m_cnt = 0; hist = '0; m_prev = 0; m_rem = 0;
        e_valid = 0; e_dut = '0; e_stim = '0;
        rst = 1'b0;
    endtask

    // predict the state after the next rising edge
    task automatic step_model();
        logic sel, edge_seen;
        int rem_eff, hh;
        hist = {hist[14:0], m_ph};
        sel = hist[latency];
        edge_seen = (sel != m_prev);
        rem_eff = edge_seen ? int'(blank_len) : m_rem;
        m_prev = sel;
        if (adc_strobe) begin
            tag_v = "R5 valid";
            if (rem_eff != 0) begin
                e_valid = 0;
                m_rem = rem_eff - 1;
                tag_d = "R6 hold";
            end else begin
                e_valid = 1;
                e_dut  = sel ? adc_b_data : adc_a_data;
                e_stim = sel ? adc_a_data : adc_b_data;
                m_rem = 0;
                tag_d = (latency != 0) ? "R4 routed" : "R3 routed";
            end
        end else begin
            e_valid = 0;
            m_rem = rem_eff;
            tag_v = "R7 valid";
            tag_d = "R7 hold";
        end
        hh = (half_period == 0) ? 1 : int'(half_period);
        if (m_cnt >= hh - 1) begin
            m_cnt = 0;
            m_ph = ~m_ph;
        end else begin
            m_cnt++;
        end
    endtask

    task automatic run(int n, int pct);
        for (int i = 0; i < n; i++) begin
            adc_strobe = ($urandom_range(99) < pct);
            adc_a_data = 14'($urandom);
            adc_b_data = 14'($urandom);
            step_model();
            @(negedge clk);
            chk("R2 phase", 32'(sw_phase), 32'(m_ph));
            chk(tag_v, 32'(out_valid), 32'(e_valid));
            chk({tag_d, " dut"}, 32'(dut_data), 32'(e_dut));
            chk({tag_d, " stim"}, 32'(stim_data), 32'(e_stim));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        // directed corners
        start_cfg(4, 0, 0);    run(400, 100);   // R3 plain crossover
        start_cfg(5, 3, 2);    run(600, 70);    // R4 R5 delayed select with blanking
        start_cfg(1, 0, 1);    run(200, 100);   // R5 select flips every edge: all blanked
        start_cfg(0, 2, 0);    run(200, 100);   // R2 zero half-period acts as one
        start_cfg(20, 15, 15); run(1500, 90);   // R4 R5 maximum delay and blanking
        start_cfg(300, 1, 3);  run(1500, 100);  // R2 long period
        start_cfg(6, 0, 4);    run(600, 30);    // R7 sparse strobes
        // random configurations
        for (int k = 0; k < 8; k++) begin
            start_cfg($urandom_range(40, 1), $urandom_range(15), $urandom_range(15));
            run(1500, $urandom_range(100, 20));
        end
        summary();
        $finish;
    end

endmodule